// File: doc/BRIEF.md
# Addressable RGB LED Chain Driver

This block drives one serial data line that feeds a chain of addressable RGB LEDs. It keeps one 24-bit colour word per LED in an internal register array. The array takes its starting contents from a parameter, and a single-cycle write port can update it. The block refreshes the chain without any external trigger. It sends every word of the chain, starting with LED 0, then holds the line low for a latch gap, and then starts the next frame.

Each bit is sent as a high pulse followed by a low pulse, and the two lengths depend on the bit value. All lengths are whole clock-cycle counts worked out at elaboration from the clock frequency and from a choice between two timing tables: the older one with a short latch gap and the newer one with a long latch gap. A synchronous reset puts the sequencer back at the start of a frame. It does not disturb the stored colours.

Top module: `ledchain_drv`

## Requirements
- R1: While `rst` is high the line is low. After the last clock edge that samples `rst` high, the line first rises on the TRST-th following rising edge and stays low until then.
- R2: LED 0 is sent first, then LED 1, and so on up to LED NUM_LEDS-1. Within a word, bit 23 is sent first and bit 0 last.
- R3: A 0 bit is a high pulse of T0H cycles followed by a low pulse of T0L cycles.
- R4: A 1 bit is a high pulse of T1H cycles followed by a low pulse of T1L cycles.
- R5: After bit 0 of the last LED, the low pulse lasts its normal length plus TRST cycles. The next frame then starts at LED 0 with no external stimulus, and frames repeat without end.
- R6: Each cycle count equals round(duration_ns × CLK_HZ / 1e9), with a minimum of 1 for high pulses and a minimum of 2 for low pulses and the gap. With NEW_TIMING=0 the durations are 400/850 ns (0 bit), 800/450 ns (1 bit) and 50 µs (gap), so at 50 MHz T0H=20, T0L=43, T1H=40, T1L=23 and TRST=2500.
- R7: With NEW_TIMING=1 the durations are 300/900 ns (0 bit), 900/300 ns (1 bit) and 280 µs (gap), so at 50 MHz T0H=15, T0L=45, T1H=45, T1L=15 and TRST=14000.
- R8: A write (`wrEn` high at a rising edge) stores `wrData` for LED `wrAddr`. The new value is used the next time that LED's word is fetched: in the current frame if the word has not been fetched yet, otherwise in the next frame.
- R9: A write whose address is NUM_LEDS or more changes no stored word.
- R10: A reset in the middle of a frame stops the frame at once, with the line low. The frame then restarts at LED 0 after a gap as in R1, and words written before the reset are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at CLK_HZ |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write strobe for one colour word |
| wrAddr | input | ADDR_W | LED index to write |
| wrData | input | 24 | Colour word to store |
| ledOut | output | 1 | Registered serial line to the LED chain |

## Verification
The hardest case to reach from the ports is a write that races the fetch pointer. One write lands in an LED whose word has already been sent this frame, and must show up only one frame later. Another write lands in an LED that has not yet been fetched, and must show up within the same frame. The stimulus counts clock cycles from reset release. It issues both writes, plus an out-of-range write, while LED 1 of the first frame is being sent. A second driver instance uses the newer timing table with a single LED, so its end-of-chain gap and the wrap to LED 0 come round every frame. A reset in the middle of a frame then checks the restart and that the stored words survive it.

// File: rtl/ledchain_pkg.sv
package ledchain_pkg;

  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_LOAD  = 2'd1,
    ST_HIGH  = 2'd2,
    ST_LOW   = 2'd3
  } phaseT;

  typedef struct packed {
    logic loadWord;
    logic shiftBit;
    logic driveHigh;
  } strobeT;

  localparam int WORD_W = 24;

  // sel: 0 zero-high, 1 zero-low, 2 one-high, 3 one-low, 4 latch gap
  function automatic longint durationNs(input bit newRev, input int sel);
    case (sel)
      0: return newRev ? 64'd300 : 64'd400;
      1: return newRev ? 64'd900 : 64'd850;
      2: return newRev ? 64'd900 : 64'd800;
      3: return newRev ? 64'd300 : 64'd450;
      default: return newRev ? 64'd280000 : 64'd50000;
    endcase
  endfunction

  function automatic int revCycles(input bit newRev, input longint hz, input int sel);
    longint c;
    longint floorC;
    c = (durationNs(newRev, sel) * hz + 64'd500000000) / 64'd1000000000;
    floorC = (sel == 0 || sel == 2) ? 64'd1 : 64'd2;
    if (c < floorC) c = floorC;
    return int'(c);
  endfunction

  function automatic int maxCycles(input bit newRev, input longint hz);
    int m;
    m = 0;
    for (int s = 0; s < 5; s++)
      if (revCycles(newRev, hz, s) > m) m = revCycles(newRev, hz, s);
    return m;
  endfunction

endpackage

// File: rtl/ledchain_ctrl.sv
module ledchain_ctrl
  import ledchain_pkg::*;
#(
  parameter longint CLK_HZ     = 50000000,
  parameter bit     NEW_TIMING = 1'b0,
  parameter int     NUM_LEDS   = 9,
  parameter int     ADDR_W     = 4,
  parameter int     CNT_W      = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              headBit,
  input  logic              followBit,
  input  logic              fetchMsb,
  output strobeT            strobe,
  output phaseT             phase,
  output logic [CNT_W-1:0]  cnt,
  output logic [4:0]        bitIdx,
  output logic [ADDR_W-1:0] ledIdx
);

  localparam logic [CNT_W-1:0] C0H  = CNT_W'(revCycles(NEW_TIMING, CLK_HZ, 0));
  localparam logic [CNT_W-1:0] C0L  = CNT_W'(revCycles(NEW_TIMING, CLK_HZ, 1));
  localparam logic [CNT_W-1:0] C1H  = CNT_W'(revCycles(NEW_TIMING, CLK_HZ, 2));
  localparam logic [CNT_W-1:0] C1L  = CNT_W'(revCycles(NEW_TIMING, CLK_HZ, 3));
  localparam logic [CNT_W-1:0] CRST = CNT_W'(revCycles(NEW_TIMING, CLK_HZ, 4));
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO  = CNT_W'(2);
  localparam logic [ADDR_W-1:0] LAST_LED = ADDR_W'(NUM_LEDS - 1);
  localparam logic [4:0] TOP_BIT = 5'(WORD_W - 1);

  phaseT             phaseN;
  logic [CNT_W-1:0]  cntN;
  logic [4:0]        bitN;
  logic [ADDR_W-1:0] ledN;
  logic              wordDone;
  logic              chainDone;

  assign wordDone  = (bitIdx == 5'd0);
  assign chainDone = wordDone && (ledIdx == LAST_LED);

  always_comb begin
    phaseN = phase;
    cntN   = cnt;
    bitN   = bitIdx;
    ledN   = ledIdx;
    strobe = '0;
    case (phase)
      ST_RESET: begin
        if (cnt == '0) phaseN = ST_LOAD;
        else           cntN = cnt - ONE;
      end
      ST_LOAD: begin
        phaseN          = ST_HIGH;
        bitN            = TOP_BIT;
        strobe.loadWord = 1'b1;
        cntN            = (fetchMsb ? C1H : C0H) - ONE;
      end
      ST_HIGH: begin
        if (cnt == '0) begin
          phaseN = ST_LOW;
          // the LOAD cycle that follows a finished word takes one low cycle
          cntN = (headBit ? C1L : C0L) - ((wordDone && !chainDone) ? TWO : ONE);
        end else begin
          cntN = cnt - ONE;
        end
      end
      default: begin
        if (cnt == '0) begin
          if (chainDone) begin
            phaseN = ST_RESET;
            ledN   = '0;
            cntN   = CRST - TWO;
          end else if (wordDone) begin
            phaseN = ST_LOAD;
            ledN   = ledIdx + ADDR_W'(1);
          end else begin
            phaseN          = ST_HIGH;
            bitN            = bitIdx - 5'd1;
            strobe.shiftBit = 1'b1;
            cntN            = (followBit ? C1H : C0H) - ONE;
          end
        end else begin
          cntN = cnt - ONE;
        end
      end
    endcase
    strobe.driveHigh = (phaseN == ST_HIGH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= ST_RESET;
      cnt    <= CRST - TWO;
      bitIdx <= TOP_BIT;
      ledIdx <= '0;
    end else begin
      phase  <= phaseN;
      cnt    <= cntN;
      bitIdx <= bitN;
      ledIdx <= ledN;
    end
  end

endmodule

// File: rtl/ledchain_data.sv
module ledchain_data
  import ledchain_pkg::*;
#(
  parameter int NUM_LEDS = 9,
  parameter int ADDR_W   = 4,
  parameter logic [NUM_LEDS*WORD_W-1:0] INIT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  strobeT            strobe,
  input  logic [ADDR_W-1:0] ledIdx,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  output logic              headBit,
  output logic              followBit,
  output logic              fetchMsb,
  output logic              ledOut
);

  logic [WORD_W-1:0] colourMem [NUM_LEDS];
  logic [WORD_W-1:0] shiftQ;
  logic [WORD_W-1:0] fetchWord;

  for (genvar i = 0; i < NUM_LEDS; i++) begin : gSlot
    initial colourMem[i] = INIT[i*WORD_W +: WORD_W];
    always_ff @(posedge clk) begin
      if (wrEn && (wrAddr == ADDR_W'(i))) colourMem[i] <= wrData;
    end
  end

  assign fetchWord = colourMem[ledIdx];
  assign fetchMsb  = fetchWord[WORD_W-1];
  assign headBit   = shiftQ[WORD_W-1];
  assign followBit = shiftQ[WORD_W-2];

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftQ <= '0;
      ledOut <= 1'b0;
    end else begin
      if (strobe.loadWord)      shiftQ <= fetchWord;
      else if (strobe.shiftBit) shiftQ <= {shiftQ[WORD_W-2:0], 1'b0};
      ledOut <= strobe.driveHigh;
    end
  end

endmodule

// File: rtl/ledchain_drv.sv
module ledchain_drv
  import ledchain_pkg::*;
#(
  parameter longint CLK_HZ     = 50000000,
  parameter bit     NEW_TIMING = 1'b0,
  parameter int     NUM_LEDS   = 9,
  parameter int     ADDR_W     = (NUM_LEDS > 1) ? $clog2(NUM_LEDS) : 1,
  parameter logic [NUM_LEDS*24-1:0] INIT = {
    24'h900000, 24'h800000, 24'h700000, 24'h600000, 24'h500000,
    24'h400000, 24'h300000, 24'h200000, 24'h100000}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [23:0]       wrData,
  output logic              ledOut
);

  localparam int CNT_W = $clog2(maxCycles(NEW_TIMING, CLK_HZ) + 1);

  strobeT            strobe;
  phaseT             ctrlPhase;
  logic [CNT_W-1:0]  ctrlCnt;
  logic [4:0]        ctrlBit;
  logic [ADDR_W-1:0] ledIdx;
  logic              headBit;
  logic              followBit;
  logic              fetchMsb;

  ledchain_ctrl #(
    .CLK_HZ(CLK_HZ), .NEW_TIMING(NEW_TIMING), .NUM_LEDS(NUM_LEDS),
    .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rst(rst), .headBit(headBit), .followBit(followBit),
    .fetchMsb(fetchMsb), .strobe(strobe), .phase(ctrlPhase),
    .cnt(ctrlCnt), .bitIdx(ctrlBit), .ledIdx(ledIdx)
  );

  ledchain_data #(
    .NUM_LEDS(NUM_LEDS), .ADDR_W(ADDR_W), .INIT(INIT)
  ) data_i (
    .clk(clk), .rst(rst), .strobe(strobe), .ledIdx(ledIdx),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .headBit(headBit), .followBit(followBit), .fetchMsb(fetchMsb),
    .ledOut(ledOut)
  );

endmodule

// File: rtl/ledchain_chk.sv
module ledchain_chk
  import ledchain_pkg::*;
#(
  parameter int NUM_LEDS = 9,
  parameter int ADDR_W   = 4,
  parameter int CNT_W    = 12
) (
  input logic              clk,
  input logic              rst,
  input phaseT             phase,
  input logic [CNT_W-1:0]  cnt,
  input logic [4:0]        bitIdx,
  input logic [ADDR_W-1:0] ledIdx,
  input logic              ledOut
);

  localparam logic [ADDR_W-1:0] LAST_LED = ADDR_W'(NUM_LEDS - 1);

  // R6: a phase only ends when its counter has run out
  assert_hold_phase_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> (phase == $past(phase)));

  // R2: a word fetch occupies exactly one cycle before its first high pulse
  assert_single_load_R2: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_LOAD) |=> (phase == ST_HIGH));

  // R3: every high pulse is followed by a low pulse
  assert_high_to_low_R3: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_HIGH && cnt == '0) |=> (phase == ST_LOW));

  // R1: the line is high only while the sequencer is in a high pulse
  assert_line_high_R1: assert property (@(posedge clk) disable iff (rst)
    ledOut |-> (phase == ST_HIGH));

  assert_line_follows_R1: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_HIGH) |-> ledOut);

  // R5: the end of the chain wraps to LED 0 via the latch gap
  assert_chain_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_LOW && cnt == '0 && bitIdx == 5'd0 && ledIdx == LAST_LED)
      |=> (phase == ST_RESET && ledIdx == '0));

  // R5: indices stay inside the chain and the word
  assert_index_range_R5: assert property (@(posedge clk) disable iff (rst)
    (ledIdx <= LAST_LED) && (bitIdx <= 5'd23));

  // R10: leaving reset always starts in the gap with the line low
  assert_reset_exit_R10: assert property (@(posedge clk)
    $fell(rst) |-> (!ledOut && phase == ST_RESET));

endmodule

bind ledchain_drv ledchain_chk #(
  .NUM_LEDS(NUM_LEDS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst(rst), .phase(ctrlPhase), .cnt(ctrlCnt),
  .bitIdx(ctrlBit), .ledIdx(ledIdx), .ledOut(ledOut)
);

// File: tb/ledchain_drv_tb.sv
module ledchain_drv_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEnA = 1'b0;
  logic [3:0] wrAddrA = '0;
  logic [23:0] wrDataA = '0;
  logic wrEnB = 1'b0;
  logic [0:0] wrAddrB = '0;
  logic [23:0] wrDataB = '0;
  logic ledA;
  logic ledB;

  int compared = 0;
  int mismatched = 0;
  bit summaryDone = 1'b0;

  // expected cycle counts at 50 MHz per R6 (index 0) and R7 (index 1)
  int t0h [2] = '{20, 15};
  int t0l [2] = '{43, 45};
  int t1h [2] = '{40, 45};
  int t1l [2] = '{23, 15};
  int trst[2] = '{2500, 14000};
  int leds[2] = '{9, 1};
  int budget[2] = '{0, 0};

  logic [23:0] memA [9] = '{24'h100000, 24'h200000, 24'h300000, 24'h400000,
                           24'h500000, 24'h600000, 24'h700000, 24'h800000,
                           24'h900000};
  logic [23:0] memB = 24'hA50000;

  always #10 clk = ~clk;

  ledchain_drv dut_i (
    .clk(clk), .rst(rst), .wrEn(wrEnA), .wrAddr(wrAddrA),
    .wrData(wrDataA), .ledOut(ledA)
  );

  ledchain_drv #(.NEW_TIMING(1'b1), .NUM_LEDS(1), .INIT(24'hA50000)) dutNew_i (
    .clk(clk), .rst(rst), .wrEn(wrEnB), .wrAddr(wrAddrB),
    .wrData(wrDataB), .ledOut(ledB)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic sampleRun(input int which, input logic lvl, input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      if (budget[which] <= 0) return;
      @(negedge clk);
      budget[which]--;
      check((which == 0) ? ledA : ledB, lvl, tag);
    end
  endtask

  // behavioural expectation of the line, one sample per clock
  task automatic runModel(input int which);
    logic [23:0] word;
    sampleRun(which, 1'b0, trst[which] - 1, "R1 gap after reset");
    while (budget[which] > 0) begin
      for (int led = 0; led < leds[which]; led++) begin
        word = (which == 0) ? memA[led] : memB;       // fetched at word start (R8)
        for (int b = 23; b >= 0; b--) begin          // MSB first, R2
          if (word[b]) begin
            sampleRun(which, 1'b1, t1h[which], "R4 high (R2 order)");
            sampleRun(which, 1'b0, t1l[which], "R4 low");
          end else begin
            sampleRun(which, 1'b0 ^ 1'b1, t0h[which], "R3 high (R2 order)");
            sampleRun(which, 1'b0, t0l[which], "R3 low");
          end
        end
      end
      sampleRun(which, 1'b0, trst[which], "R5 end-of-chain gap");
    end
  endtask

  task automatic writeA(input logic [3:0] a, input logic [23:0] d);
    wrEnA = 1'b1; wrAddrA = a; wrDataA = d;
    @(negedge clk);
    wrEnA = 1'b0;
    if (a < 4'd9) memA[a] = d;   // R9: out-of-range leaves the model untouched
  endtask

  task automatic summary();
    if (!summaryDone) begin
      summaryDone = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    // R1: line low while reset is held
    repeat (4) begin
      @(negedge clk);
      check(ledA, 1'b0, "R1 during reset (old)");
      check(ledB, 1'b0, "R1 during reset (new, R7)");
    end
    rst = 1'b0;
    budget[0] = 40000;
    budget[1] = 40000;
    fork
      runModel(0);
      runModel(1);
      begin
        // LED 1 of frame 1 is on the line here
        repeat (4600) @(negedge clk);
        writeA(4'd6, 24'h00FF0F);   // R8: not yet fetched, visible this frame
        writeA(4'd0, 24'hABCDEF);   // R8: already sent, visible next frame
        writeA(4'd12, 24'hFFFFFF);  // R9: beyond the chain, ignored
        wrEnB = 1'b1; wrAddrB = 1'b1; wrDataB = 24'h000000;  // R9 on one-LED chain
        @(negedge clk);
        wrEnB = 1'b0;
      end
    join
    // R10: reset in the middle of a frame
    repeat (700) @(negedge clk);
    rst = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(ledA, 1'b0, "R10 mid-frame reset (old)");
      check(ledB, 1'b0, "R10 mid-frame reset (new)");
    end
    rst = 1'b0;
    budget[0] = 20000;
    budget[1] = 20000;
    fork
      runModel(0);
      runModel(1);
    join
    summary();
    $finish;
  end

endmodule